// File: doc/BRIEF.md
# Nibble-Packed Tag Range Checker

This block decides whether a memory access may proceed by comparing the 4-bit tag carried in the pointer with the tags held in a tag RAM. Each tag RAM byte holds the tags of two adjacent 16-byte granules. The block walks every granule that the access touches and reads one tag byte at a time through a byte-wide port with one cycle of read latency. It stops at the first granule whose tag differs from the pointer tag. It then reports pass or fail, the number of granules that matched before the walk stopped, and a fault address that is exact to the granule.

A request carries the pointer, a byte size and a direction flag. In the reverse direction the pointer names the last byte of the region, and the walk moves towards lower addresses. Two bypass conditions skip the walk altogether: top-byte checking disabled for the pointer's address half, and a match-all tag value. Two flags mark whether the pointer's own page and the neighbouring page hold untagged memory. A granule on an untagged page counts as matching and is never read, so an access that crosses a page boundary is handled in one walk. The block takes a new request only while it is idle, and it signals completion with a single-cycle `done`.

Top module: `tag_range_checker`

## Requirements
- R1: After a synchronous reset, `done`, `pass`, `bypassed` and `tag_rd_en` are low and `req_ready` is high.
- R2: The tag of the granule at address A is held in tag RAM byte (A >> 5), truncated to the RAM address width. Bits 3:0 of that byte hold the granule with A bit 4 clear, and bits 7:4 hold the granule with A bit 4 set. A forward access covers every granule from align16(ptr) to align16(ptr+size-1), where a size of 0 counts as 1. It passes with `match_cnt` equal to that granule count when every tag equals pointer bits 59:56.
- R3: The forward walk may begin on the upper nibble of a byte. It compares granules in rising address order, stops at the first mismatch and reports in `match_cnt` the number of matches before that mismatch.
- R4: When a forward access fails with `match_cnt` = 0, `fault_addr` is the pointer. When it fails with `match_cnt` = n > 0, `fault_addr` is align16(ptr) + 16·n. On a pass, `fault_addr` is the pointer.
- R5: With `rev`=1 the pointer is the last byte of the region. The walk runs from align16(ptr) down to align16(ptr-size+1), upper nibble before lower nibble. A failure with n > 0 matches reports align16(ptr) − 16·n + 15, and a failure with n = 0 reports the pointer.
- R6: If `tbi_en[ptr[55]]` is 0, the access is unchecked. `done` rises on the cycle after acceptance with `pass`=1, `bypassed`=1 and `match_cnt`=0, and no tag byte is read.
- R7: If `matchall_en[ptr[55]]` is 1 and the pointer tag is 0x0 (with ptr[55]=0) or 0xF (with ptr[55]=1), the access passes as in R6. Any other tag is checked normally.
- R8: A granule whose page (address bits above 11) equals the pointer's page uses `pg_self_untagged`, and any other granule uses `pg_other_untagged`. A granule on an untagged page counts as a match without a read.
- R9: A request is taken only when `req` and `req_ready` are both high. `req_ready` stays low from acceptance of a checked access until its `done`. A `req` during that time is ignored. `done` lasts one cycle, and the result outputs hold until the next `done`.
- R10: `tag_rd_en` is a single-cycle pulse issued only while busy. The block uses `tag_rd_data` on the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request will be taken |
| ptr | input | ADDR_W | Access pointer with tag in bits 59:56 |
| size | input | SIZE_W | Access size in bytes (0 treated as 1) |
| rev | input | 1 | 1: pointer is last byte, walk downwards |
| tbi_en | input | 2 | Top-byte checking enable per address half |
| matchall_en | input | 2 | Match-all bypass enable per address half |
| pg_self_untagged | input | 1 | Pointer's page holds no tags |
| pg_other_untagged | input | 1 | Neighbouring page holds no tags |
| tag_rd_en | output | 1 | Tag RAM read strobe |
| tag_rd_addr | output | TAG_AW | Tag RAM byte address |
| tag_rd_data | input | 8 | Tag RAM byte, valid one cycle after the strobe |
| done | output | 1 | Result valid pulse |
| pass | output | 1 | Access allowed |
| bypassed | output | 1 | Access was not checked |
| match_cnt | output | CNT_W | Granules matched before the stop |
| fault_addr | output | ADDR_W | First failing address, or the pointer |

## Verification
On every cycle the assertions check the handshake and the read port. `done` is a pulse that only appears while idle, reads are isolated pulses that never occur while idle, a bypass finishes on the following cycle with zero matches, and a pass or a first-granule failure reports the accepted pointer as fault address. Only the bench scenarios can show that the right nibble of the right byte is compared. The same holds for the walk in each direction stopping where the preloaded tags say it should, the exact fault address for failures deep in the range, and the page flags switching at a 4 KiB boundary.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_REQ  = 2'd2,
    ST_FILL = 2'd3
  } walk_st_e;

  // Tag value that matches everything for the given address half.
  function automatic logic [3:0] match_all_tag(input logic upper_half);
    return upper_half ? 4'hF : 4'h0;
  endfunction

endpackage

// File: rtl/tagchk_span.sv
module tagchk_span #(
  parameter int ADDR_W   = 64,
  parameter int SIZE_W   = 12,
  parameter int CNT_W    = 9,
  parameter int GRAN_LSB = 4
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [SIZE_W-1:0] size,
  input  logic              rev,
  input  logic [1:0]        tbi_en,
  input  logic [1:0]        matchall_en,
  output logic [ADDR_W-1:0] start_g,
  output logic [CNT_W-1:0]  count,
  output logic [3:0]        ptag,
  output logic              bypass
);
  localparam int TAG_LO  = ADDR_W - 8;
  localparam int SEL_BIT = ADDR_W - 9;
  localparam logic [ADDR_W-1:0] GMASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] size_ext, sizem1, lo_byte, hi_byte, lo_g, hi_g, span;
  logic              sel;

  always_comb begin
    size_ext = ADDR_W'(size);
    sizem1   = (size == '0) ? '0 : size_ext - ADDR_W'(1);
    lo_byte  = rev ? (ptr - sizem1) : ptr;
    hi_byte  = rev ? ptr : (ptr + sizem1);
    lo_g     = lo_byte & GMASK;
    hi_g     = hi_byte & GMASK;
    span     = (hi_g - lo_g) >> GRAN_LSB;
    count    = CNT_W'(span + ADDR_W'(1));
    start_g  = rev ? hi_g : lo_g;
    sel      = ptr[SEL_BIT];
    ptag     = ptr[TAG_LO +: 4];
    bypass   = !tbi_en[sel] ||
               (matchall_en[sel] && (ptag == tagchk_pkg::match_all_tag(sel)));
  end

endmodule

// File: rtl/tagchk_fault.sv
module tagchk_fault #(
  parameter int ADDR_W   = 64,
  parameter int CNT_W    = 9,
  parameter int GRAN_LSB = 4
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] base_g,
  input  logic [CNT_W-1:0]  n,
  input  logic              rev,
  output logic [ADDR_W-1:0] fault
);
  localparam logic [ADDR_W-1:0] LAST_OFS = (ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1);

  logic [ADDR_W-1:0] step_bytes, up_addr, down_addr;

  always_comb begin
    step_bytes = ADDR_W'(n) << GRAN_LSB;
    up_addr    = base_g + step_bytes;
    down_addr  = base_g - step_bytes + LAST_OFS;
    if (n == '0) fault = ptr;
    else         fault = rev ? down_addr : up_addr;
  end

endmodule

// File: rtl/tagchk_walker.sv
module tagchk_walker #(
  parameter int ADDR_W    = 64,
  parameter int CNT_W     = 9,
  parameter int TAG_AW    = 10,
  parameter int PAGE_BITS = 12,
  parameter int GRAN_LSB  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bypass_hit,
  input  logic [ADDR_W-1:0] in_ptr,
  input  logic [ADDR_W-1:0] in_start_g,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [3:0]        in_ptag,
  input  logic              in_rev,
  input  logic              in_self_u,
  input  logic              in_other_u,
  output logic              idle,
  output logic              tag_rd_en,
  output logic [TAG_AW-1:0] tag_rd_addr,
  input  logic [7:0]        tag_rd_data,
  output logic              done,
  output logic              pass,
  output logic              bypassed,
  output logic [CNT_W-1:0]  match_cnt,
  output logic [ADDR_W-1:0] fault_addr
);
  import tagchk_pkg::*;

  localparam int PG_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] GSTEP = ADDR_W'(1) << GRAN_LSB;

  walk_st_e          state;
  logic [ADDR_W-1:0] cur_g, ptr_q, base_q;
  logic [CNT_W-1:0]  remain, n_q;
  logic [3:0]        ptag_q;
  logic              rev_q, self_u_q, other_u_q;
  logic [PG_W-1:0]   page_q;
  logic [TAG_AW-1:0] cb_addr;
  logic              cb_val;
  logic [7:0]        cb_data;

  logic [TAG_AW-1:0] cur_byte;
  logic              cur_hi, cur_untag, cache_hit, gran_ok;
  logic [3:0]        cur_nib;
  logic [ADDR_W-1:0] fault_w, next_g;

  always_comb begin
    cur_byte  = cur_g[GRAN_LSB+1 +: TAG_AW];
    cur_hi    = cur_g[GRAN_LSB];
    cur_untag = (cur_g[ADDR_W-1:PAGE_BITS] == page_q) ? self_u_q : other_u_q;
    cache_hit = cb_val && (cb_addr == cur_byte);
    cur_nib   = cur_hi ? cb_data[7:4] : cb_data[3:0];
    gran_ok   = cur_untag || (cache_hit && (cur_nib == ptag_q));
    next_g    = rev_q ? (cur_g - GSTEP) : (cur_g + GSTEP);
  end

  assign idle = (state == ST_IDLE);

  tagchk_fault #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .GRAN_LSB(GRAN_LSB)
  ) u_fault (
    .ptr   (ptr_q),
    .base_g(base_q),
    .n     (n_q),
    .rev   (rev_q),
    .fault (fault_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cur_g       <= '0;
      ptr_q       <= '0;
      base_q      <= '0;
      remain      <= '0;
      n_q         <= '0;
      ptag_q      <= '0;
      rev_q       <= 1'b0;
      self_u_q    <= 1'b0;
      other_u_q   <= 1'b0;
      page_q      <= '0;
      cb_addr     <= '0;
      cb_val      <= 1'b0;
      cb_data     <= '0;
      tag_rd_en   <= 1'b0;
      tag_rd_addr <= '0;
      done        <= 1'b0;
      pass        <= 1'b0;
      bypassed    <= 1'b0;
      match_cnt   <= '0;
      fault_addr  <= '0;
    end else begin
      done      <= 1'b0;
      tag_rd_en <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (bypass_hit) begin
            done       <= 1'b1;
            pass       <= 1'b1;
            bypassed   <= 1'b1;
            match_cnt  <= '0;
            fault_addr <= in_ptr;
          end else if (start) begin
            cur_g     <= in_start_g;
            base_q    <= in_start_g;
            ptr_q     <= in_ptr;
            remain    <= in_count;
            n_q       <= '0;
            ptag_q    <= in_ptag;
            rev_q     <= in_rev;
            self_u_q  <= in_self_u;
            other_u_q <= in_other_u;
            page_q    <= in_ptr[ADDR_W-1:PAGE_BITS];
            cb_val    <= 1'b0;
            state     <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (remain == '0) begin
            done       <= 1'b1;
            pass       <= 1'b1;
            bypassed   <= 1'b0;
            match_cnt  <= n_q;
            fault_addr <= ptr_q;
            state      <= ST_IDLE;
          end else if (gran_ok) begin
            n_q    <= n_q + CNT_W'(1);
            remain <= remain - CNT_W'(1);
            cur_g  <= next_g;
          end else if (!cache_hit) begin
            tag_rd_en   <= 1'b1;
            tag_rd_addr <= cur_byte;
            state       <= ST_REQ;
          end else begin
            done       <= 1'b1;
            pass       <= 1'b0;
            bypassed   <= 1'b0;
            match_cnt  <= n_q;
            fault_addr <= fault_w;
            state      <= ST_IDLE;
          end
        end
        ST_REQ: begin
          state <= ST_FILL;
        end
        ST_FILL: begin
          cb_data <= tag_rd_data;
          cb_addr <= tag_rd_addr;
          cb_val  <= 1'b1;
          state   <= ST_STEP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tag_range_checker.sv
module tag_range_checker #(
  parameter int ADDR_W    = 64,
  parameter int SIZE_W    = 12,
  parameter int TAG_AW    = 10,
  parameter int PAGE_BITS = 12,
  localparam int CNT_W    = SIZE_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [SIZE_W-1:0] size,
  input  logic              rev,
  input  logic [1:0]        tbi_en,
  input  logic [1:0]        matchall_en,
  input  logic              pg_self_untagged,
  input  logic              pg_other_untagged,
  output logic              tag_rd_en,
  output logic [TAG_AW-1:0] tag_rd_addr,
  input  logic [7:0]        tag_rd_data,
  output logic              done,
  output logic              pass,
  output logic              bypassed,
  output logic [CNT_W-1:0]  match_cnt,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int GRAN_LSB = 4;

  logic [ADDR_W-1:0] sp_start;
  logic [CNT_W-1:0]  sp_count;
  logic [3:0]        sp_ptag;
  logic              sp_bypass, idle, accept;

  tagchk_span #(
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W),
    .CNT_W   (CNT_W),
    .GRAN_LSB(GRAN_LSB)
  ) u_span (
    .ptr        (ptr),
    .size       (size),
    .rev        (rev),
    .tbi_en     (tbi_en),
    .matchall_en(matchall_en),
    .start_g    (sp_start),
    .count      (sp_count),
    .ptag       (sp_ptag),
    .bypass     (sp_bypass)
  );

  assign req_ready = idle;
  assign accept    = req && idle;

  tagchk_walker #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .TAG_AW   (TAG_AW),
    .PAGE_BITS(PAGE_BITS),
    .GRAN_LSB (GRAN_LSB)
  ) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start      (accept && !sp_bypass),
    .bypass_hit (accept && sp_bypass),
    .in_ptr     (ptr),
    .in_start_g (sp_start),
    .in_count   (sp_count),
    .in_ptag    (sp_ptag),
    .in_rev     (rev),
    .in_self_u  (pg_self_untagged),
    .in_other_u (pg_other_untagged),
    .idle       (idle),
    .tag_rd_en  (tag_rd_en),
    .tag_rd_addr(tag_rd_addr),
    .tag_rd_data(tag_rd_data),
    .done       (done),
    .pass       (pass),
    .bypassed   (bypassed),
    .match_cnt  (match_cnt),
    .fault_addr (fault_addr)
  );

endmodule

// File: rtl/tag_range_checker_sva.sv
module tag_range_checker_sva #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              req_ready,
  input logic [ADDR_W-1:0] ptr,
  input logic [1:0]        tbi_en,
  input logic              tag_rd_en,
  input logic              done,
  input logic              pass,
  input logic              bypassed,
  input logic [CNT_W-1:0]  match_cnt,
  input logic [ADDR_W-1:0] fault_addr
);
  localparam int SEL_BIT = ADDR_W - 9;

  logic [ADDR_W-1:0] acc_ptr;

  always_ff @(posedge clk) begin
    if (rst) acc_ptr <= '0;
    else if (req && req_ready) acc_ptr <= ptr;
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  p_bypass_fast_r6: assert property (@(posedge clk) disable iff (rst)
    (req && req_ready && !tbi_en[ptr[SEL_BIT]]) |=> (done && pass && bypassed));

  p_bypass_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (done && bypassed) |-> (pass && match_cnt == '0));

  p_fault_is_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    (done && (pass || match_cnt == '0)) |-> (fault_addr == acc_ptr));

  p_no_read_idle_r10: assert property (@(posedge clk) disable iff (rst)
    tag_rd_en |-> !req_ready);

  p_read_single_r10: assert property (@(posedge clk) disable iff (rst)
    tag_rd_en |=> !tag_rd_en);

endmodule

bind tag_range_checker tag_range_checker_sva #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .req_ready (req_ready),
  .ptr       (ptr),
  .tbi_en    (tbi_en),
  .tag_rd_en (tag_rd_en),
  .done      (done),
  .pass      (pass),
  .bypassed  (bypassed),
  .match_cnt (match_cnt),
  .fault_addr(fault_addr)
);

// File: tb/tag_range_checker_bench.sv
`timescale 1ns/1ps
module tag_range_checker_bench;
  localparam int ADDR_W = 64;
  localparam int SIZE_W = 12;
  localparam int TAG_AW = 10;
  localparam int CNT_W  = SIZE_W - 3;

  typedef struct packed {
    logic [63:0] ptr;
    logic [11:0] size;
    logic        rev;
    logic [1:0]  tbi;
    logic [1:0]  mall;
    logic        su;
    logic        ou;
    logic        e_pass;
    logic        e_byp;
    logic [8:0]  e_n;
    logic [63:0] e_fault;
    logic        noread;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    // R2 aligned forward pass
    '{64'h0300_0000_0000_0100, 12'd64, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 9'd4, 64'h0300_0000_0000_0100, 1'b0, 4'd2},
    // R2 size zero counts as one byte
    '{64'h0300_0000_0000_0100, 12'd0,  1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 9'd1, 64'h0300_0000_0000_0100, 1'b0, 4'd2},
    // R3 odd nibble start, fails on third granule
    '{64'h0300_0000_0000_01F8, 12'd32, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd2, 64'h0300_0000_0000_0210, 1'b0, 4'd3},
    // R4 first granule fails, fault is pointer
    '{64'h0300_0000_0000_0210, 12'd1,  1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 64'h0300_0000_0000_0210, 1'b0, 4'd4},
    // R3 odd nibble start pass across a byte
    '{64'h0300_0000_0000_01F4, 12'd16, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 9'd2, 64'h0300_0000_0000_01F4, 1'b0, 4'd3},
    // R5 reverse pass
    '{64'h0300_0000_0000_020F, 12'd40, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 9'd3, 64'h0300_0000_0000_020F, 1'b0, 4'd5},
    // R5 reverse fail deep in range
    '{64'h0300_0000_0000_020F, 12'd80, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd4, 64'h0300_0000_0000_01CF, 1'b0, 4'd5},
    // R5 reverse first granule fail on upper nibble
    '{64'h0300_0000_0000_021F, 12'd16, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 64'h0300_0000_0000_021F, 1'b0, 4'd5},
    // R8 page crossing, both pages tagged
    '{64'h0300_0000_0000_0FF0, 12'd48, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 64'h0300_0000_0000_0FF0, 1'b0, 4'd8},
    // R8 own page untagged, fails on next page
    '{64'h0300_0000_0000_0FF0, 12'd48, 1'b0, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 9'd2, 64'h0300_0000_0000_1010, 1'b0, 4'd8},
    // R8 crossing, tagged next page fails
    '{64'h0300_0000_0000_1FE0, 12'd64, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd3, 64'h0300_0000_0000_2010, 1'b0, 4'd8},
    // R8 crossing, next page untagged passes
    '{64'h0300_0000_0000_1FE0, 12'd64, 1'b0, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 9'd4, 64'h0300_0000_0000_1FE0, 1'b0, 4'd8},
    // R8 both pages untagged, no reads
    '{64'h0300_0000_0000_0FF0, 12'd48, 1'b0, 2'b11, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 9'd3, 64'h0300_0000_0000_0FF0, 1'b1, 4'd8},
    // R5 reverse crossing, own page tagged fails
    '{64'h0300_0000_0000_201F, 12'd48, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 64'h0300_0000_0000_201F, 1'b0, 4'd5},
    // R8 reverse crossing, own page untagged
    '{64'h0300_0000_0000_201F, 12'd48, 1'b1, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 9'd3, 64'h0300_0000_0000_201F, 1'b0, 4'd8},
    // R6 checking disabled for lower half
    '{64'h0300_0000_0000_0210, 12'd1,  1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 64'h0300_0000_0000_0210, 1'b1, 4'd6},
    // R6 only upper half disabled, lower checked
    '{64'h0300_0000_0000_0210, 12'd1,  1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 64'h0300_0000_0000_0210, 1'b0, 4'd6},
    // R7 match-all tag 0 in lower half
    '{64'h0000_0000_0000_0210, 12'd1,  1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 64'h0000_0000_0000_0210, 1'b1, 4'd7},
    // R7 match-all enabled for other half only
    '{64'h0000_0000_0000_0210, 12'd1,  1'b0, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 64'h0000_0000_0000_0210, 1'b0, 4'd7},
    // R7 match-all tag F in upper half
    '{64'h0F80_0000_0000_0210, 12'd1,  1'b0, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 64'h0F80_0000_0000_0210, 1'b1, 4'd7},
    // R7 tag 0 in upper half is not match-all
    '{64'h0080_0000_0000_0210, 12'd1,  1'b0, 2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 64'h0080_0000_0000_0210, 1'b0, 4'd7},
    // R2 pointer tag 5 matches upper nibble
    '{64'h0500_0000_0000_0210, 12'd1,  1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 9'd1, 64'h0500_0000_0000_0210, 1'b0, 4'd2}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              req;
  logic              req_ready;
  logic [ADDR_W-1:0] ptr;
  logic [SIZE_W-1:0] size;
  logic              rev;
  logic [1:0]        tbi_en, matchall_en;
  logic              pg_self_untagged, pg_other_untagged;
  logic              tag_rd_en;
  logic [TAG_AW-1:0] tag_rd_addr;
  logic [7:0]        tag_rd_data;
  logic              done, pass, bypassed;
  logic [CNT_W-1:0]  match_cnt;
  logic [ADDR_W-1:0] fault_addr;

  logic [7:0] tmem [1 << TAG_AW];
  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  int b2b = 0;
  logic rd_prev = 1'b0;

  always #2.5 clk = ~clk;

  tag_range_checker u_tag_range_checker (
    .clk(clk), .rst(rst), .req(req), .req_ready(req_ready), .ptr(ptr),
    .size(size), .rev(rev), .tbi_en(tbi_en), .matchall_en(matchall_en),
    .pg_self_untagged(pg_self_untagged), .pg_other_untagged(pg_other_untagged),
    .tag_rd_en(tag_rd_en), .tag_rd_addr(tag_rd_addr), .tag_rd_data(tag_rd_data),
    .done(done), .pass(pass), .bypassed(bypassed), .match_cnt(match_cnt),
    .fault_addr(fault_addr)
  );

  always_ff @(posedge clk) if (tag_rd_en) tag_rd_data <= tmem[tag_rd_addr];

  always @(posedge clk) begin
    if (tag_rd_en) rd_cnt++;
    if (done) done_cnt++;
    if (tag_rd_en && rd_prev) b2b++;
    rd_prev = tag_rd_en;
  end

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ptr = v.ptr; size = v.size; rev = v.rev; tbi_en = v.tbi;
    matchall_en = v.mall; pg_self_untagged = v.su; pg_other_untagged = v.ou;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk(1'b0, 9, "timeout waiting for done", 0, 1);
  endtask

  task automatic run_vec(input vec_t v);
    int lat;
    int rd0;
    while (!req_ready) @(negedge clk);
    drive(v);
    req = 1'b1;
    rd0 = rd_cnt;
    @(negedge clk);
    req = 1'b0;
    if (!v.e_byp) chk(!req_ready, 9, "ready low while busy", 64'(req_ready), 0);
    wait_done(lat);
    chk(pass == v.e_pass, int'(v.rq), "pass", 64'(pass), 64'(v.e_pass));
    chk(bypassed == v.e_byp, int'(v.rq), "bypassed", 64'(bypassed), 64'(v.e_byp));
    chk(match_cnt == v.e_n, int'(v.rq), "match_cnt", 64'(match_cnt), 64'(v.e_n));
    chk(fault_addr == v.e_fault, int'(v.rq), "fault_addr", fault_addr, v.e_fault);
    if (v.e_byp) chk(lat == 0, 6, "bypass latency", 64'(lat), 0);
    if (v.noread) chk(rd_cnt == rd0, int'(v.rq), "tag reads", 64'(rd_cnt - rd0), 0);
    @(negedge clk);
    chk(!done && pass == v.e_pass, 9, "done pulse and result hold",
        {62'd0, done, pass}, {62'd0, 1'b0, v.e_pass});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int d0;
    for (int i = 0; i < (1 << TAG_AW); i++) tmem[i] = 8'h33;
    tmem[10'h00E] = 8'h36;
    tmem[10'h010] = 8'h53;
    tmem[10'h07F] = 8'h93;
    tmem[10'h080] = 8'h73;
    tmem[10'h100] = 8'hA3;
    rst = 1'b1; req = 1'b0;
    drive(VECS[0]);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!done && !pass && !bypassed && !tag_rd_en, 1, "outputs after reset",
        {60'd0, done, pass, bypassed, tag_rd_en}, 0);
    chk(req_ready, 1, "ready after reset", 64'(req_ready), 1);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R9: a request during a busy walk is ignored
    while (!req_ready) @(negedge clk);
    d0 = done_cnt;
    drive(VECS[10]);
    req = 1'b1;
    @(negedge clk);
    drive(VECS[15]);
    @(negedge clk);
    req = 1'b0;
    wait_done(lat);
    chk(pass == 1'b0 && match_cnt == 9'd3, 9, "busy request ignored result",
        {54'd0, pass, match_cnt}, {54'd0, 1'b0, 9'd3});
    chk(fault_addr == 64'h0300_0000_0000_2010, 9, "busy request ignored fault",
        fault_addr, 64'h0300_0000_0000_2010);
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, 9, "single done for busy case", 64'(done_cnt - d0), 1);

    // R10 reads are isolated pulses
    chk(b2b == 0, 10, "back-to-back reads", 64'(b2b), 0);
    chk(rd_cnt > 0, 10, "tag reads issued", 64'(rd_cnt), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule